// File: doc/BRIEF.md
# Memory map test and sizing engine

This block is the start-up sequencer that prepares a paged memory system. After reset it exercises every entry of the page-map RAM in two passes. It then finds out which physical pages actually exist and work, packs those pages into consecutive map entries, marks every other map entry vacant, and clears the usable pages to zero. Finally it reports how many good pages it found. If the map RAM is broken, or if too little memory was found, it reports a failure code.

The engine owns two ports. One reaches the map RAM: address, write data, write strobe, read strobe and read data. The other reaches physical memory, one quadword (four data words) per access. It carries a page number, a quadword index, write and read strobes, 4-word write and read data, and a fault flag. Both ports return read data, and the fault flag, on the clock edge after the read strobe. The map RAM hands back the complement of the value that was written to it.

The sequence starts by itself when synchronous reset is released. It needs no start command. The parameters assume that the map has at least as many entries as there are physical pages, and that a page holds at least five quadwords.

Top module: `mms_engine`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `done` is 0, `fail_code` is 0 and `good_pages` is 0. The sequence then runs without any further input.
- R2: Map test. In the first pass, each entry i is written with i XOR all-ones and read back. The second pass repeats this with i unchanged. An entry passes when the read data XNOR the written value is all zeros, because the RAM returns the complement. Any failure in either pass ends the run with `done`=1, `fail_code`=102 and `good_pages`=0, and no physical memory access takes place.
- R3: Tagging visits the pages from the highest page number down to page 0, so the first memory write goes to the top page. Each page receives five quadwords, where word k occupies bits 16k+15:16k:
  - quadword 0: four copies of the page number;
  - quadword 1: four copies of its complement;
  - quadword 2: 0x8000 in word 0;
  - quadword 3: 0x0001 in word 1;
  - quadword 4: 0x4000 in word 2.
  All other words are zero.
- R4: The check pass reads quadwords 0 to 4 of each page in ascending page order. A page is rejected in any of these cases:
  - a read returns a fault;
  - any word of quadword 0 differs from the page number;
  - any word of quadword 1 differs from the complement of the page number.
- R5: Accepted pages are written, as their page numbers and in ascending order, into map entries 0, 1, 2 and so on. `good_pages` equals the number of accepted pages.
- R6: Every map entry above the last accepted one, up to the end of the map, is written with the vacant code 0x6000.
- R7: Every quadword of every accepted page is written to zero. Rejected pages are never written during this clearing phase.
- R8: At the end of the run, `done` rises and stays high until reset. `fail_code` is 101 if `good_pages` is below MIN_GOOD, and 0 otherwise.
- R9: The fault flag is acted on only for check-pass reads. A fault on a tag write is ignored, the tag is still stored, and a fault never stops the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_addr | output | MAP_AW | Map entry address |
| map_we | output | 1 | Map write strobe |
| map_re | output | 1 | Map read strobe |
| map_wdata | output | DW | Map write data |
| map_rdata | input | DW | Complemented map read data, valid the cycle after map_re |
| mem_page | output | PAGE_AW | Physical page number |
| mem_quad | output | QAW | Quadword index within the page |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 4*DW | Quadword write data, word k in bits 16k+15:16k |
| mem_rdata | input | 4*DW | Quadword read data, valid the cycle after mem_re |
| mem_fault | input | 1 | Access fault, aligned with mem_rdata |
| good_pages | output | PAGE_AW+1 | Number of accepted pages |
| done | output | 1 | Sequence finished |
| fail_code | output | 7 | 0 on success, 101 for too little memory, 102 for a map failure |

## Verification
- **Read checks.** A map read is answered one edge after `map_re`, and the engine judges it in the state that follows. Memory read data and faults likewise arrive one edge after `mem_re`. The bench's RAM models reproduce exactly that one-edge latency, so every comparison in the engine meets its data on time.
- **Final results.** The count, the failure code and the contents of the map and of memory are all settled in the cycle `done` rises. The scoreboard monitor pops its expected items on the first falling edge where `done` is high, after the last write edge.
- **First tag write.** The page of the first memory write is captured on the falling edge of the cycle that drives it.
- **Holding.** Five cycles later, a second check confirms that `done` and the code have held.

// File: rtl/mms_pkg.sv
// Shared types and constants for the memory map test and sizing engine.
package mms_pkg;
    typedef enum logic [3:0] {
        S_MWR,   // map test: write entry
        S_MRD,   // map test: read entry
        S_MCK,   // map test: judge read data
        S_TAG,   // write tag quadwords, pages descending
        S_CRD,   // check pass: read a tag quadword
        S_CEV,   // check pass: judge it
        S_ACC,   // record an accepted page in the map
        S_VAC,   // fill the rest of the map with the vacant code
        S_ZRD,   // clear phase: read map entry
        S_ZCAP,  // clear phase: capture page number
        S_ZWR,   // clear phase: write zero quadwords
        S_END    // finished
    } mms_state_e;

    localparam logic [6:0]  FAIL_MEM   = 7'd101;
    localparam logic [6:0]  FAIL_MAP   = 7'd102;
    localparam logic [15:0] VACANT     = 16'h6000;
    localparam int          LAST_TAGQ  = 4;
endpackage

// File: rtl/mms_tagpat.sv
// Tag pattern generator.
// Produces the quadword written to physical memory for a given page and
// quadword index, or all zeros when the clear phase is active.
// Assumes four data words per quadword and DW >= 2.
module mms_tagpat #(
    parameter int DW      = 16,
    parameter int PAGE_AW = 4,
    parameter int QAW     = 3
) (
    input  logic [PAGE_AW-1:0] page,
    input  logic [QAW-1:0]     quad,
    input  logic               zero,
    output logic [4*DW-1:0]    wdata
);
    localparam logic [DW-1:0] HI_BIT  = DW'(1) << (DW-1);
    localparam logic [DW-1:0] MID_BIT = DW'(1) << (DW-2);
    localparam logic [DW-1:0] LO_BIT  = DW'(1);

    logic [DW-1:0] pg_word;
    assign pg_word = DW'(page);

    for (genvar k = 0; k < 4; k++) begin : g_word
        // select the value for word k of the current quadword
        always_comb begin
            wdata[k*DW +: DW] = '0;
            if (!zero) begin
                case (int'(quad))
                    0: wdata[k*DW +: DW] = pg_word;
                    1: wdata[k*DW +: DW] = ~pg_word;
                    2: wdata[k*DW +: DW] = (k == 0) ? HI_BIT  : '0;
                    3: wdata[k*DW +: DW] = (k == 1) ? LO_BIT  : '0;
                    4: wdata[k*DW +: DW] = (k == 2) ? MID_BIT : '0;
                    default: wdata[k*DW +: DW] = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/mms_judge.sv
// Comparison logic.
// map_ok:   the complemented map read data matches the expected value
//           (an XNOR of the two is all zeros).
// page_bad: a tag read faulted, or a word of quadword 0 or 1 disagrees
//           with the page number or its complement.
// Purely combinational; the controller decides when each output is used.
module mms_judge #(
    parameter int DW      = 16,
    parameter int PAGE_AW = 4,
    parameter int QAW     = 3
) (
    input  logic [DW-1:0]      map_rdata,
    input  logic [DW-1:0]      map_expect,
    input  logic [4*DW-1:0]    mem_rdata,
    input  logic               mem_fault,
    input  logic [PAGE_AW-1:0] page,
    input  logic [QAW-1:0]     quad,
    output logic               map_ok,
    output logic               page_bad
);
    logic [3:0] miss_num, miss_cmp;
    logic [DW-1:0] pg_word;

    assign pg_word = DW'(page);
    assign map_ok  = ~|(map_rdata ~^ map_expect);

    for (genvar k = 0; k < 4; k++) begin : g_cmp
        assign miss_num[k] = (mem_rdata[k*DW +: DW] != pg_word);
        assign miss_cmp[k] = (mem_rdata[k*DW +: DW] != ~pg_word);
    end

    // reject on fault or on a tag mismatch in the two numbered quadwords
    always_comb begin
        page_bad = mem_fault;
        if (quad == QAW'(0) && |miss_num) page_bad = 1'b1;
        if (quad == QAW'(1) && |miss_cmp) page_bad = 1'b1;
    end
endmodule

// File: rtl/mms_ctrl.sv
// Sequencing controller.
// Steps through map test, tagging, check pass, map fill, vacant fill and
// page clearing, and holds the count, done flag and failure code.
// Assumes 1-cycle read latency on both ports, 2**MAP_AW >= 2**PAGE_AW
// and at least five quadwords per page.
module mms_ctrl
    import mms_pkg::*;
#(
    parameter int DW       = 16,
    parameter int MAP_AW   = 5,
    parameter int PAGE_AW  = 4,
    parameter int QAW      = 3,
    parameter int MIN_GOOD = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               map_ok,
    input  logic               page_bad,
    input  logic [DW-1:0]      map_rdata,
    output logic [MAP_AW-1:0]  map_addr,
    output logic               map_we,
    output logic               map_re,
    output logic [DW-1:0]      map_wdata,
    output logic [DW-1:0]      map_expect,
    output logic [PAGE_AW-1:0] mem_page,
    output logic [QAW-1:0]     mem_quad,
    output logic               mem_we,
    output logic               mem_re,
    output logic               mem_zero,
    output logic [PAGE_AW:0]   good_pages,
    output logic               done,
    output logic [6:0]         fail_code
);
    localparam int IW = MAP_AW + 1;
    localparam int CW = PAGE_AW + 1;

    mms_state_e         state;
    logic [IW-1:0]      idx;
    logic               pass_inv;
    logic [PAGE_AW-1:0] page;
    logic [QAW-1:0]     quad;
    logic [IW-1:0]      mptr;
    logic [CW-1:0]      cnt;
    logic [PAGE_AW-1:0] zpage;
    logic               done_q;
    logic [6:0]         code_q;
    logic               zero_end;

    assign map_expect = DW'(idx[MAP_AW-1:0]) ^ {DW{pass_inv}};
    assign zero_end   = (idx == IW'(cnt));
    assign good_pages = cnt;
    assign done       = done_q;
    assign fail_code  = code_q;

    // drive port strobes, addresses and data from the current state
    always_comb begin
        map_addr  = idx[MAP_AW-1:0];
        map_we    = 1'b0;
        map_re    = 1'b0;
        map_wdata = map_expect;
        mem_page  = page;
        mem_quad  = quad;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_zero  = 1'b0;
        case (state)
            S_MWR: map_we = 1'b1;
            S_MRD: map_re = 1'b1;
            S_TAG: mem_we = 1'b1;
            S_CRD: mem_re = 1'b1;
            S_ACC: begin
                map_we    = 1'b1;
                map_addr  = mptr[MAP_AW-1:0];
                map_wdata = DW'(page);
            end
            S_VAC: begin
                map_we    = ~mptr[MAP_AW];
                map_addr  = mptr[MAP_AW-1:0];
                map_wdata = DW'(VACANT);
            end
            S_ZRD: map_re = ~zero_end;
            S_ZWR: begin
                mem_we   = 1'b1;
                mem_page = zpage;
                mem_zero = 1'b1;
            end
            default: ;
        endcase
    end

    // advance the sequence and update counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_MWR;
            idx      <= '0;
            pass_inv <= 1'b1;
            page     <= '0;
            quad     <= '0;
            mptr     <= '0;
            cnt      <= '0;
            zpage    <= '0;
            done_q   <= 1'b0;
            code_q   <= '0;
        end else begin
            case (state)
                S_MWR: state <= S_MRD;
                S_MRD: state <= S_MCK;
                S_MCK: begin
                    if (!map_ok) begin
                        code_q <= FAIL_MAP;
                        done_q <= 1'b1;
                        state  <= S_END;
                    end else if (&idx[MAP_AW-1:0]) begin
                        idx <= '0;
                        if (pass_inv) begin
                            pass_inv <= 1'b0;
                            state    <= S_MWR;
                        end else begin
                            page  <= '1;
                            quad  <= '0;
                            state <= S_TAG;
                        end
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= S_MWR;
                    end
                end
                S_TAG: begin
                    if (quad == QAW'(LAST_TAGQ)) begin
                        quad <= '0;
                        if (page == '0) state <= S_CRD;
                        else            page  <= page - 1'b1;
                    end else begin
                        quad <= quad + 1'b1;
                    end
                end
                S_CRD: state <= S_CEV;
                S_CEV: begin
                    if (page_bad) begin
                        quad <= '0;
                        if (&page) state <= S_VAC;
                        else begin
                            page  <= page + 1'b1;
                            state <= S_CRD;
                        end
                    end else if (quad == QAW'(LAST_TAGQ)) begin
                        state <= S_ACC;
                    end else begin
                        quad  <= quad + 1'b1;
                        state <= S_CRD;
                    end
                end
                S_ACC: begin
                    mptr <= mptr + 1'b1;
                    cnt  <= cnt + 1'b1;
                    quad <= '0;
                    if (&page) state <= S_VAC;
                    else begin
                        page  <= page + 1'b1;
                        state <= S_CRD;
                    end
                end
                S_VAC: begin
                    if (mptr[MAP_AW]) begin
                        idx   <= '0;
                        state <= S_ZRD;
                    end else begin
                        mptr <= mptr + 1'b1;
                    end
                end
                S_ZRD: begin
                    if (zero_end) begin
                        done_q <= 1'b1;
                        code_q <= (32'(cnt) < MIN_GOOD) ? FAIL_MEM : 7'd0;
                        state  <= S_END;
                    end else begin
                        state <= S_ZCAP;
                    end
                end
                S_ZCAP: begin
                    zpage <= ~map_rdata[PAGE_AW-1:0];
                    quad  <= '0;
                    state <= S_ZWR;
                end
                S_ZWR: begin
                    if (&quad) begin
                        idx   <= idx + 1'b1;
                        state <= S_ZRD;
                    end else begin
                        quad <= quad + 1'b1;
                    end
                end
                S_END: ;
                default: state <= S_END;
            endcase
        end
    end
endmodule

// File: rtl/mms_engine.sv
// Memory map test and sizing engine, top level.
// Connects the controller, the tag pattern generator and the comparison
// logic to the map RAM port and the physical memory port.
// Assumes registered, 1-cycle-latency RAMs on both ports.
module mms_engine #(
    parameter int DW       = 16,
    parameter int MAP_AW   = 5,
    parameter int PAGE_AW  = 4,
    parameter int QAW      = 3,
    parameter int MIN_GOOD = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [MAP_AW-1:0]  map_addr,
    output logic               map_we,
    output logic               map_re,
    output logic [DW-1:0]      map_wdata,
    input  logic [DW-1:0]      map_rdata,
    output logic [PAGE_AW-1:0] mem_page,
    output logic [QAW-1:0]     mem_quad,
    output logic               mem_we,
    output logic               mem_re,
    output logic [4*DW-1:0]    mem_wdata,
    input  logic [4*DW-1:0]    mem_rdata,
    input  logic               mem_fault,
    output logic [PAGE_AW:0]   good_pages,
    output logic               done,
    output logic [6:0]         fail_code
);
    logic          map_ok, page_bad, mem_zero;
    logic [DW-1:0] map_expect;

    mms_ctrl #(
        .DW(DW), .MAP_AW(MAP_AW), .PAGE_AW(PAGE_AW),
        .QAW(QAW), .MIN_GOOD(MIN_GOOD)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .map_ok(map_ok), .page_bad(page_bad), .map_rdata(map_rdata),
        .map_addr(map_addr), .map_we(map_we), .map_re(map_re),
        .map_wdata(map_wdata), .map_expect(map_expect),
        .mem_page(mem_page), .mem_quad(mem_quad),
        .mem_we(mem_we), .mem_re(mem_re), .mem_zero(mem_zero),
        .good_pages(good_pages), .done(done), .fail_code(fail_code)
    );

    mms_tagpat #(.DW(DW), .PAGE_AW(PAGE_AW), .QAW(QAW)) u_pat (
        .page(mem_page), .quad(mem_quad), .zero(mem_zero), .wdata(mem_wdata)
    );

    mms_judge #(.DW(DW), .PAGE_AW(PAGE_AW), .QAW(QAW)) u_judge (
        .map_rdata(map_rdata), .map_expect(map_expect),
        .mem_rdata(mem_rdata), .mem_fault(mem_fault),
        .page(mem_page), .quad(mem_quad),
        .map_ok(map_ok), .page_bad(page_bad)
    );
endmodule

// File: rtl/mms_engine_chk.sv
// Property checker for mms_engine, attached with bind below.
// Observes only the top-level ports.
module mms_engine_chk #(
    parameter int DW       = 16,
    parameter int MAP_AW   = 5,
    parameter int PAGE_AW  = 4,
    parameter int MIN_GOOD = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [MAP_AW-1:0]  map_addr,
    input logic               map_we,
    input logic               map_re,
    input logic [DW-1:0]      map_wdata,
    input logic               mem_we,
    input logic               mem_re,
    input logic [PAGE_AW:0]   good_pages,
    input logic               done,
    input logic [6:0]         fail_code
);
    logic primed;

    // mark cycles whose previous edge was already out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    assert_code_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_code != 7'd0) |-> done);

    assert_pass_enough_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail_code == 7'd0) |-> (32'(good_pages) >= MIN_GOOD));

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (good_pages == $past(good_pages) ||
                    good_pages == $past(good_pages) + 1'b1));

    assert_vacant_above_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (map_we && map_wdata == DW'(16'h6000)) |-> (32'(map_addr) >= 32'(good_pages)));

    assert_mapfail_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_code == 7'd102) |-> (!mem_we && !mem_re && good_pages == '0));

    assert_port_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re) && !(map_we && map_re));
endmodule

bind mms_engine mms_engine_chk #(
    .DW(DW), .MAP_AW(MAP_AW), .PAGE_AW(PAGE_AW), .MIN_GOOD(MIN_GOOD)
) u_chk (
    .clk(clk), .rst_n(rst_n), .map_addr(map_addr), .map_we(map_we),
    .map_re(map_re), .map_wdata(map_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .good_pages(good_pages), .done(done), .fail_code(fail_code)
);

// File: tb/sim_mms_engine.sv
// Scoreboard bench for mms_engine: a driver task pushes expected items,
// a monitor pops and compares them once the engine reports done.
module sim_mms_engine;
    localparam int DW = 16, MAP_AW = 5, PAGE_AW = 4, QAW = 3, MIN_GOOD = 8;
    localparam int MAP_N = 1 << MAP_AW, PAGE_N = 1 << PAGE_AW, QN = 1 << QAW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [MAP_AW-1:0]  map_addr;
    logic               map_we, map_re;
    logic [DW-1:0]      map_wdata;
    logic [DW-1:0]      map_rdata = '0;
    logic [PAGE_AW-1:0] mem_page;
    logic [QAW-1:0]     mem_quad;
    logic               mem_we, mem_re;
    logic [4*DW-1:0]    mem_wdata;
    logic [4*DW-1:0]    mem_rdata = '0;
    logic               mem_fault = 1'b0;
    logic [PAGE_AW:0]   good_pages;
    logic               done;
    logic [6:0]         fail_code;

    always #10 clk = ~clk;

    mms_engine #(.DW(DW), .MAP_AW(MAP_AW), .PAGE_AW(PAGE_AW), .QAW(QAW),
                 .MIN_GOOD(MIN_GOOD)) u0 (
        .clk(clk), .rst_n(rst_n), .map_addr(map_addr), .map_we(map_we),
        .map_re(map_re), .map_wdata(map_wdata), .map_rdata(map_rdata),
        .mem_page(mem_page), .mem_quad(mem_quad), .mem_we(mem_we),
        .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_fault(mem_fault), .good_pages(good_pages), .done(done),
        .fail_code(fail_code)
    );

    // models and their configuration
    logic [DW-1:0] map_mem [0:MAP_N-1];
    logic [63:0]   pmem [0:PAGE_N*QN-1];
    logic [PAGE_N-1:0] fault_pg, hole_pg, flip0_pg, flip1_pg, late_pg;
    int            stuck_idx;
    logic [DW-1:0] stuck0, stuck1;

    // map RAM stores writes (with optional stuck bits) and returns complement
    always @(posedge clk) begin
        if (rst_n && map_we)
            map_mem[map_addr] <= (int'(map_addr) == stuck_idx) ?
                ((map_wdata & ~stuck0) | stuck1) : map_wdata;
        if (map_re) map_rdata <= ~map_mem[map_addr];
    end

    // physical memory with holes, faults and read-data corruption
    always @(posedge clk) begin
        if (rst_n && mem_we && !hole_pg[mem_page])
            pmem[{mem_page, mem_quad}] <= mem_wdata;
        if (mem_re)
            mem_rdata <= hole_pg[mem_page] ? 64'd0 :
                (pmem[{mem_page, mem_quad}]
                 ^ ((flip0_pg[mem_page] && mem_quad == 3'd0) ? 64'd1 : 64'd0)
                 ^ ((flip1_pg[mem_page] && mem_quad == 3'd1) ? 64'd1 : 64'd0));
        mem_fault <= rst_n && (mem_we || mem_re) &&
                     (fault_pg[mem_page] || (late_pg[mem_page] && mem_quad == 3'd3));
    end

    typedef struct {
        int          kind;   // 0 map entry, 1 quadword, 2 count, 3 code, 4 first tag, 5 done
        int          idx;
        logic [63:0] val;
        string       req;
    } item_t;
    item_t sbq[$];

    int  checks = 0, errors = 0, cycles = 0;
    bit  scored = 1'b0, tag_seen = 1'b0;
    int  first_tag = -1;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(int kind, int idx, logic [63:0] val, string req);
        item_t it;
        it.kind = kind; it.idx = idx; it.val = val; it.req = req;
        sbq.push_back(it);
    endtask

    // monitor: first tag write, and scoring once done is seen
    always @(negedge clk) begin
        if (rst_n && mem_we && !tag_seen) begin
            first_tag = int'(mem_page);
            tag_seen = 1'b1;
        end
        if (rst_n && done && !scored) begin
            while (sbq.size() > 0) begin
                item_t it;
                logic [63:0] act;
                it = sbq.pop_front();
                case (it.kind)
                    0: act = 64'(map_mem[it.idx]);
                    1: act = pmem[it.idx];
                    2: act = 64'(good_pages);
                    3: act = 64'(fail_code);
                    4: act = 64'(first_tag);
                    default: act = 64'(done);
                endcase
                check(it.req, act, it.val);
            end
            scored = 1'b1;
        end
    end

    // watchdog: a hung run is a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected done", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic set_cfg(logic [PAGE_N-1:0] f, logic [PAGE_N-1:0] h,
                           logic [PAGE_N-1:0] x0, logic [PAGE_N-1:0] x1,
                           logic [PAGE_N-1:0] lt, int si,
                           logic [DW-1:0] s0, logic [DW-1:0] s1);
        fault_pg = f; hole_pg = h; flip0_pg = x0; flip1_pg = x1; late_pg = lt;
        stuck_idx = si; stuck0 = s0; stuck1 = s1;
    endtask

    // driver: build expectations, reset the engine, wait for scoring
    task automatic run_case();
        logic [DW-1:0] v1, v2;
        bit map_fail;
        int good [$];
        int exp_code;
        rst_n = 1'b0;
        scored = 1'b0;
        tag_seen = 1'b0;
        first_tag = -1;
        for (int i = 0; i < MAP_N; i++) map_mem[i] = 16'h1234;
        for (int i = 0; i < PAGE_N*QN; i++) pmem[i] = 64'hA5A5_A5A5_A5A5_A5A5;
        map_fail = 1'b0;
        if (stuck_idx >= 0) begin
            v1 = ~DW'(stuck_idx);
            v2 = DW'(stuck_idx);
            if (((v1 & ~stuck0) | stuck1) != v1) map_fail = 1'b1;
            if (((v2 & ~stuck0) | stuck1) != v2) map_fail = 1'b1;
        end
        if (map_fail) begin
            exp_code = 102;
            push(3, 0, 64'd102, "R2 map fault code");
            push(2, 0, 64'd0, "R2 count after map fault");
            push(4, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R2 no memory write");
            push(5, 0, 64'd1, "R2 done after map fault");
        end else begin
            for (int p = 0; p < PAGE_N; p++)
                if (!fault_pg[p] && !hole_pg[p] && !flip0_pg[p] && !flip1_pg[p] && !late_pg[p])
                    good.push_back(p);
            exp_code = (good.size() < MIN_GOOD) ? 101 : 0;
            for (int i = 0; i < MAP_N; i++)
                if (i < good.size()) push(0, i, 64'(good[i]), "R5 map entry");
                else                 push(0, i, 64'h6000, "R6 vacant entry");
            push(2, 0, 64'(good.size()), "R5 good count");
            push(3, 0, 64'(exp_code), "R8 code");
            push(4, 0, 64'(PAGE_N - 1), "R3 first tag page");
            push(5, 0, 64'd1, "R8 done");
            for (int i = 0; i < good.size(); i++) begin
                push(1, good[i]*QN, 64'd0, "R7 cleared quad0");
                push(1, good[i]*QN + QN - 1, 64'd0, "R7 cleared last quad");
            end
            for (int p = 0; p < PAGE_N; p++)
                if (fault_pg[p] && !hole_pg[p]) begin
                    push(1, p*QN, {4{DW'(p)}}, "R9 tag kept on faulting page");
                    push(1, p*QN + 1, {4{~DW'(p)}}, "R3 complement tag");
                    push(1, p*QN + 2, 64'h0000_0000_0000_8000, "R3 quad2 pattern");
                    push(1, p*QN + 3, 64'h0000_0000_0001_0000, "R3 quad3 pattern");
                    push(1, p*QN + 4, 64'h0000_4000_0000_0000, "R3 quad4 pattern");
                    push(1, p*QN + 5, 64'hA5A5_A5A5_A5A5_A5A5, "R7 rejected page untouched");
                end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 done in reset", 64'(done), 64'd0);
        check("R1 code in reset", 64'(fail_code), 64'd0);
        check("R1 count in reset", 64'(good_pages), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after release", 64'(done), 64'd0);
        wait (scored);
        repeat (5) @(negedge clk);
        check("R8 done held", 64'(done), 64'd1);
        check("R8 code held", 64'(fail_code), 64'(exp_code));
    endtask

    initial begin
        // all pages good
        set_cfg('0, '0, '0, '0, '0, -1, '0, '0);
        run_case();
        // fault, hole, tag miscompares, late fault on quadword 3 (R4, R9)
        set_cfg(16'h0008, 16'h0300, 16'h0020, 16'h0800, 16'h2000, -1, '0, '0);
        run_case();
        // too few pages: holes on 0..9 (R8 code 101)
        set_cfg('0, 16'h03FF, '0, '0, '0, -1, '0, '0);
        run_case();
        // map bit stuck at 0, found in first pass (R2)
        set_cfg('0, '0, '0, '0, '0, 7, 16'h8000, '0);
        run_case();
        // map bit stuck at 1, found only in second pass (R2)
        set_cfg('0, '0, '0, '0, '0, 4, '0, 16'h0001);
        run_case();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule